// File: doc/BRIEF.md
# Four-Port Cell Transmit Slave

This block sits on the ingress side of a cell transmit link and serves four ports that share one 32-bit word bus. An ATM layer device drives words, a start-of-cell marker, an active-low enable, a two-bit port address and a parity bit. All of these are sampled on the rising edge of the transmit clock. The block latches the target port from the address bus on every cycle where enable is high. It frames the words of each 14-word cell per port and checks parity on every enabled word. It forwards each accepted word one cycle later to the storage of the addressed port on a write bus. That write bus marks the first word and the last word of each cell.

The block keeps, for each port, the number of committed cells held in storage and whether a cell is being assembled. From these it works out whether there is room for one more complete cell. The result is shown on four direct available flags, or on one shared flag that answers for whichever port the address bus presents. The line side returns space one cell at a time through a per-port release strobe. A cell that is cut short by a new start-of-cell is dropped and counted. Parity faults raise a sticky flag for each port.

Top module: `cell_tx_slave`

## Requirements
- R1: The selected port is loaded from `tx_addr` on each rising edge where `tx_en_n` is 1 and holds while `tx_en_n` is 0. Address value n selects port n, and a word taken with `tx_en_n` at 0 goes to the port held at that moment.
- R2: A word with `tx_soc` at 1 opens a new cell only when the port holds fewer than `FIFO_CELLS` committed cells. Otherwise it is not written. A word with `tx_soc` at 0 on a port with no open cell is not written. In both cases `wr_vld` stays 0.
- R3: Each accepted word appears on `wr_data` and `wr_port` with `wr_vld` at 1 on the cycle after the edge that took it. `wr_first` is 1 for a word that opened a cell.
- R4: The 14th word of a cell carries `wr_last` at 1 and adds one committed cell to its port.
- R5: A `tx_soc` that arrives while a port's cell is still open discards the partial cell and starts a new one. It also adds one to that port's drop counter, which saturates at its maximum. Port p's counter is `err_cnt[p*ERR_W +: ERR_W]`.
- R6: On every edge with `tx_en_n` at 0, parity is checked over the 32 data bits and `tx_par`. With `par_odd` at 0 the total count of ones must be even, and with `par_odd` at 1 it must be odd. A mismatch sets `perr[p]` for the selected port p, and the word is still written.
- R7: `perr` bits stay set until `perr_clr` is 1 on an edge, which clears all of them. A new fault on that same edge leaves its port's bit set.
- R8: With `poll_mode` at 0, `clav[p]` is 1 exactly when the committed cells of port p plus its open cell (0 or 1) number fewer than `FIFO_CELLS`.
- R9: With `poll_mode` at 1, `clav[0]` shows the R8 status of the port currently on `tx_addr`, and the other `clav` bits are 0.
- R10: `cell_rel[p]` at 1 on an edge removes one committed cell from port p if it holds any.
- R11: After reset the block has no open or committed cells, all `perr` bits and drop counters are 0, `wr_vld` is 0, and in direct mode every `clav` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_data | input | 32 | Cell word, bit 31 most significant |
| tx_soc | input | 1 | Start-of-cell marker on the first word |
| tx_en_n | input | 1 | Word enable, active low |
| tx_addr | input | 2 | Port address |
| tx_par | input | 1 | Parity bit over `tx_data` |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| poll_mode | input | 1 | 1 selects the shared polled flag |
| perr_clr | input | 1 | Clears all parity flags |
| cell_rel | input | 4 | Per-port release of one stored cell |
| clav | output | 4 | Cell-space flags |
| perr | output | 4 | Sticky per-port parity fault |
| err_cnt | output | 32 | Four 8-bit drop counters, port 0 in the low byte |
| wr_vld | output | 1 | Write strobe to port storage |
| wr_port | output | 2 | Port of the written word |
| wr_data | output | 32 | Written word |
| wr_first | output | 1 | Word opened a cell |
| wr_last | output | 1 | Word closed a cell |

## Verification
A wrong per-port word count first shows as `wr_last` on the wrong word, or as a missing drop count when the next start-of-cell arrives. It shows at the latest on the next write bus cycle for that port. A wrong cell count shows up on `clav` as soon as that port nears its limit. It also surfaces as a start-of-cell that is refused or wrongly accepted. A stale selected-port register shows on `wr_port` on the first word after the address cycle. The reference model is compared on every clock, so any of these shows within one cycle of the first edge where the state matters.

// File: rtl/cts_pkg.sv
package cts_pkg;

   // parity sense encoding on par_odd
   typedef enum logic {
      PAR_EVEN = 1'b0,
      PAR_ODD  = 1'b1
   } par_sense_e;

   // cell-space reporting variants chosen at elaboration
   localparam int unsigned STAT_DIRECT_ONLY = 0;
   localparam int unsigned STAT_WITH_POLL   = 1;

endpackage

// File: rtl/cts_addr_latch.sv
module cts_addr_latch #(
   parameter int unsigned AW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_n,
   input  logic [AW-1:0] addr,
   output logic [AW-1:0] sel
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sel <= '0;
      else if (en_n) sel <= addr;
   end

   // R1
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_n |=> sel == $past(sel));

endmodule

// File: rtl/cts_parity.sv
module cts_parity #(
   parameter int unsigned DW = 32
) (
   input  logic [DW-1:0] data,
   input  logic          par,
   input  logic          odd,
   output logic          bad
);
   import cts_pkg::*;

   logic ones_odd;

   assign ones_odd = ^{data, par};
   // even sense wants an even total, odd sense an odd one
   assign bad = (par_sense_e'(odd) == PAR_ODD) ? !ones_odd : ones_odd;

endmodule

// File: rtl/cts_port_ctrl.sv
module cts_port_ctrl #(
   parameter int unsigned CELL_WORDS = 14,
   parameter int unsigned FIFO_CELLS = 4,
   parameter int unsigned ERR_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             soc,
   input  logic             par_bad,
   input  logic             perr_clr,
   input  logic             rel,
   output logic             acc,
   output logic             first,
   output logic             last,
   output logic             space,
   output logic             perr,
   output logic [ERR_W-1:0] err_cnt
);

   localparam int unsigned WCW = $clog2(CELL_WORDS + 1);
   localparam int unsigned CCW = $clog2(FIFO_CELLS + 1);

   logic [WCW-1:0] wcnt;
   logic [WCW-1:0] wnext;
   logic [CCW-1:0] cells;
   logic           open_c;
   logic           start_ok;
   logic           drop;
   logic           cell_dec;

   assign open_c   = (wcnt != '0);
   assign start_ok = soc && (cells < CCW'(FIFO_CELLS));
   assign acc      = hit && (soc ? start_ok : open_c);
   assign first    = acc && soc;
   assign wnext    = soc ? WCW'(1) : wcnt + WCW'(1);
   assign last     = acc && (wnext == WCW'(CELL_WORDS));
   assign drop     = hit && soc && open_c;
   assign cell_dec = rel && (cells != '0);
   assign space    = (int'(cells) + int'(open_c)) < int'(FIFO_CELLS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt <= '0;
      end else if (acc) begin
         wcnt <= last ? '0 : wnext;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cells <= '0;
      end else begin
         case ({last, cell_dec})
            2'b10:   cells <= cells + CCW'(1);
            2'b01:   cells <= cells - CCW'(1);
            default: cells <= cells;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      err_cnt <= '0;
      else if (drop && err_cnt != '1)  err_cnt <= err_cnt + ERR_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) perr <= 1'b0;
      else        perr <= (perr && !perr_clr) || (hit && par_bad);
   end

   // R4
   cells_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cells) <= int'(FIFO_CELLS));

   // R4
   word_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wcnt) < int'(CELL_WORDS));

   // R10
   rel_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel && !last && cells != '0 |=> cells == $past(cells) - CCW'(1));

   // R5
   err_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 err_cnt >= $past(err_cnt));

   // R6
   perr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit && par_bad |=> perr);

   // R7
   perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      perr && !perr_clr |=> perr);

endmodule

// File: rtl/cts_status.sv
module cts_status #(
   parameter int unsigned NP      = 4,
   parameter int unsigned AW      = 2,
   parameter int unsigned STAT_MD = 1
) (
   input  logic          poll,
   input  logic [AW-1:0] addr,
   input  logic [NP-1:0] space,
   output logic [NP-1:0] clav
);
   import cts_pkg::*;

   generate
      if (STAT_MD == STAT_WITH_POLL) begin : g_poll
         assign clav = poll ? {{(NP-1){1'b0}}, space[addr]} : space;
      end else begin : g_direct
         logic unused_in;
         assign unused_in = poll ^ (^addr);
         assign clav = space;
      end
   endgenerate

endmodule

// File: rtl/cell_tx_slave.sv
module cell_tx_slave #(
   parameter int unsigned DW         = 32,
   parameter int unsigned NP         = 4,
   parameter int unsigned CELL_WORDS = 14,
   parameter int unsigned FIFO_CELLS = 4,
   parameter int unsigned ERR_W      = 8,
   parameter int unsigned STAT_MD    = 1,
   localparam int unsigned AW        = $clog2(NP)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DW-1:0]    tx_data,
   input  logic             tx_soc,
   input  logic             tx_en_n,
   input  logic [AW-1:0]    tx_addr,
   input  logic             tx_par,
   input  logic             par_odd,
   input  logic             poll_mode,
   input  logic             perr_clr,
   input  logic [NP-1:0]    cell_rel,
   output logic [NP-1:0]    clav,
   output logic [NP-1:0]    perr,
   output logic [NP*ERR_W-1:0] err_cnt,
   output logic             wr_vld,
   output logic [AW-1:0]    wr_port,
   output logic [DW-1:0]    wr_data,
   output logic             wr_first,
   output logic             wr_last
);

   generate
      if (NP < 2 || (1 << AW) != NP) begin : g_bad_np
         $error("NP must be a power of two of at least 2");
      end
      if (CELL_WORDS < 2) begin : g_bad_cw
         $error("CELL_WORDS must be at least 2");
      end
      if (FIFO_CELLS < 1) begin : g_bad_fc
         $error("FIFO_CELLS must be at least 1");
      end
      if (ERR_W < 1) begin : g_bad_ew
         $error("ERR_W must be at least 1");
      end
   endgenerate

   logic [AW-1:0] sel;
   logic          par_bad;
   logic [NP-1:0] hit, acc, first, last, space;

   cts_addr_latch #(.AW(AW)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .en_n  (tx_en_n),
      .addr  (tx_addr),
      .sel   (sel)
   );

   cts_parity #(.DW(DW)) u_par (
      .data (tx_data),
      .par  (tx_par),
      .odd  (par_odd),
      .bad  (par_bad)
   );

   generate
      for (genvar p = 0; p < NP; p++) begin : g_port
         assign hit[p] = !tx_en_n && (sel == AW'(p));
         cts_port_ctrl #(
            .CELL_WORDS (CELL_WORDS),
            .FIFO_CELLS (FIFO_CELLS),
            .ERR_W      (ERR_W)
         ) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hit[p]),
            .soc      (tx_soc),
            .par_bad  (par_bad),
            .perr_clr (perr_clr),
            .rel      (cell_rel[p]),
            .acc      (acc[p]),
            .first    (first[p]),
            .last     (last[p]),
            .space    (space[p]),
            .perr     (perr[p]),
            .err_cnt  (err_cnt[p*ERR_W +: ERR_W])
         );
      end
   endgenerate

   cts_status #(.NP(NP), .AW(AW), .STAT_MD(STAT_MD)) u_stat (
      .poll  (poll_mode),
      .addr  (tx_addr),
      .space (space),
      .clav  (clav)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_vld   <= 1'b0;
         wr_port  <= '0;
         wr_data  <= '0;
         wr_first <= 1'b0;
         wr_last  <= 1'b0;
      end else begin
         wr_vld   <= |acc;
         wr_first <= |first;
         wr_last  <= |last;
         if (|acc) begin
            wr_port <= sel;
            wr_data <= tx_data;
         end
      end
   end

   // R3
   wr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 wr_vld |-> $past(!tx_en_n));

   // R4
   last_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_last |-> wr_vld);

   // R3
   acc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(acc));

endmodule

// File: tb/sim_cell_tx_slave.sv
module sim_cell_tx_slave;

   localparam int CLK_T = 10;
   localparam int NPT   = 4;
   localparam int CW    = 14;
   localparam int FC    = 4;
   localparam int EMAX  = 255;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] tx_data = '0;
   logic        tx_soc = 1'b0;
   logic        tx_en_n = 1'b1;
   logic [1:0]  tx_addr = '0;
   logic        tx_par = 1'b0;
   logic        par_odd = 1'b0;
   logic        poll_mode = 1'b0;
   logic        perr_clr = 1'b0;
   logic [3:0]  cell_rel = '0;
   logic [3:0]  clav, perr;
   logic [31:0] err_cnt;
   logic        wr_vld, wr_first, wr_last;
   logic [1:0]  wr_port;
   logic [31:0] wr_data;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #(CLK_T/2) clk = ~clk;

   cell_tx_slave u0 (
      .clk, .rst_n, .tx_data, .tx_soc, .tx_en_n, .tx_addr, .tx_par,
      .par_odd, .poll_mode, .perr_clr, .cell_rel, .clav, .perr, .err_cnt,
      .wr_vld, .wr_port, .wr_data, .wr_first, .wr_last
   );

   // ---------------- reference model ----------------
   int          m_wcnt[NPT];
   int          m_cells[NPT];
   int          m_err[NPT];
   bit          m_perr[NPT];
   int          m_sel;
   bit          e_vld, e_first, e_last;
   int          e_port;
   logic [31:0] e_data;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int q = 0; q < NPT; q++) begin
            m_wcnt[q] = 0; m_cells[q] = 0; m_err[q] = 0; m_perr[q] = 0;
         end
         m_sel = 0; e_vld = 0; e_first = 0; e_last = 0;
      end else begin
         int  p;
         bit  take, inc, bad;
         p = m_sel; take = 0; inc = 0;
         e_vld = 0; e_first = 0; e_last = 0;
         bad = ($countones({tx_data, tx_par}) % 2) != (par_odd ? 1 : 0);
         if (perr_clr) for (int q = 0; q < NPT; q++) m_perr[q] = 0;
         if (!tx_en_n) begin
            if (bad) m_perr[p] = 1;
            if (tx_soc) begin
               if (m_wcnt[p] != 0) begin
                  m_wcnt[p] = 0;
                  if (m_err[p] < EMAX) m_err[p]++;
               end
               if (m_cells[p] < FC) begin
                  take = 1; e_first = 1; m_wcnt[p] = 1;
               end
            end else if (m_wcnt[p] != 0) begin
               take = 1; m_wcnt[p]++;
            end
            if (take && m_wcnt[p] == CW) begin
               m_wcnt[p] = 0; inc = 1; e_last = 1;
            end
            if (take) begin
               e_vld = 1; e_port = p; e_data = tx_data;
            end
         end
         for (int q = 0; q < NPT; q++)
            if (cell_rel[q] && m_cells[q] > 0) m_cells[q]--;
         if (inc) m_cells[p]++;
         if (tx_en_n) m_sel = int'(tx_addr);
      end
   end

   function automatic bit m_space(int q);
      return (m_cells[q] + ((m_wcnt[q] != 0) ? 1 : 0)) < FC;
   endfunction

   // ---------------- checking ----------------
   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic cmp_all();
      logic [3:0] ec;
      for (int q = 0; q < NPT; q++) ec[q] = m_space(q);
      if (poll_mode) begin
         ec = {3'b000, m_space(int'(tx_addr))};
         chk(clav == ec, "R9 clav", 64'(clav), 64'(ec));
      end else begin
         chk(clav == ec, "R8 clav", 64'(clav), 64'(ec));
      end
      for (int q = 0; q < NPT; q++) begin
         chk(perr[q] == m_perr[q], "R6 perr", 64'(perr[q]), 64'(m_perr[q]));
         chk(int'(err_cnt[q*8 +: 8]) == m_err[q], "R5 err_cnt",
             64'(err_cnt[q*8 +: 8]), 64'(m_err[q]));
      end
      chk(wr_vld == e_vld, "R3 wr_vld", 64'(wr_vld), 64'(e_vld));
      if (wr_vld && e_vld) begin
         chk(int'(wr_port) == e_port, "R1 wr_port", 64'(wr_port), 64'(e_port));
         chk(wr_data == e_data, "R3 wr_data", 64'(wr_data), 64'(e_data));
         chk(wr_first == e_first, "R2 wr_first", 64'(wr_first), 64'(e_first));
         chk(wr_last == e_last, "R4 wr_last", 64'(wr_last), 64'(e_last));
      end
   endtask

   // wait for the falling edge, compare, then apply new inputs
   task automatic drv(input bit en_n, input bit soc, input int addr,
                      input bit par_err);
      logic [31:0] d;
      @(negedge clk);
      cmp_all();
      d = $urandom;
      tx_en_n  = en_n;
      tx_soc   = soc;
      tx_addr  = 2'(addr);
      tx_data  = d;
      tx_par   = (par_odd ? ~^d : ^d) ^ par_err;
      cell_rel = '0;
      perr_clr = 1'b0;
   endtask

   task automatic send_cell(input int port, input int nw, input int bad_at);
      drv(1, 0, port, 0);
      for (int w = 0; w < nw; w++) drv(0, w == 0, (port + w) % NPT, w == bad_at);
   endtask

   task automatic fin();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
         fin();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(clav == 4'hf, "R11 clav", 64'(clav), 64'hf);
      chk(perr == 4'h0 && err_cnt == 0, "R11 flags", 64'({perr, err_cnt}), 64'h0);
      chk(wr_vld == 1'b0, "R11 wr_vld", 64'(wr_vld), 64'h0);
      rst_n = 1'b1;

      // one full cell to each port; address changes mid-cell are ignored (R1)
      for (int p = 0; p < NPT; p++) send_cell(p, CW, -1);
      drv(1, 0, 0, 0);

      // fill port 0, then a fifth start is refused (R2)
      for (int k = 0; k < FC - 1; k++) send_cell(0, CW, -1);
      drv(1, 0, 0, 0);
      drv(1, 0, 0, 0);
      chk(clav[0] == 1'b0, "R8 port0 full", 64'(clav[0]), 64'h0);
      send_cell(0, 3, -1);
      drv(1, 0, 0, 0);
      chk(wr_vld == 1'b0, "R2 refused start", 64'(wr_vld), 64'h0);
      // release one cell (R10)
      cell_rel = 4'b0001;
      drv(1, 0, 0, 0);
      chk(clav[0] == 1'b1, "R10 release", 64'(clav[0]), 64'h1);

      // idle words without a start are not written (R2)
      drv(1, 0, 2, 0);
      drv(0, 0, 2, 0);
      drv(0, 0, 2, 0);
      chk(wr_vld == 1'b0, "R2 stray word", 64'(wr_vld), 64'h0);

      // partial cell cut by a new start (R5), interleaved resume
      send_cell(1, 5, -1);
      send_cell(2, 4, -1);
      drv(1, 0, 1, 0);
      for (int w = 0; w < CW - 5; w++) drv(0, 0, 1, 0);
      send_cell(2, 1, -1);
      drv(1, 0, 0, 0);
      drv(1, 0, 0, 0);
      chk(err_cnt[23:16] == 8'd1, "R5 drop count", 64'(err_cnt[23:16]), 64'h1);

      // parity in both senses (R6), clear with coincident fault (R7)
      send_cell(3, CW, 4);
      par_odd = 1'b1;
      send_cell(1, CW, 7);
      drv(1, 0, 2, 0);
      drv(0, 1, 2, 1);
      perr_clr = 1'b1;
      drv(1, 0, 2, 0);
      drv(1, 0, 2, 0);
      chk(perr == 4'b0100, "R7 clear with new fault", 64'(perr), 64'h4);
      perr_clr = 1'b1;
      drv(1, 0, 2, 0);
      drv(1, 0, 2, 0);
      chk(perr == 4'b0000, "R7 clear", 64'(perr), 64'h0);
      par_odd = 1'b0;

      // polling mode (R9)
      poll_mode = 1'b1;
      for (int p = 0; p < NPT; p++) drv(1, 0, p, 0);
      for (int p = 0; p < NPT; p++) drv(1, 0, p, 0);
      poll_mode = 1'b0;

      // drop counter saturation on port 3 (R5)
      drv(1, 0, 3, 0);
      for (int k = 0; k < EMAX + 8; k++) drv(0, 1, 3, 0);
      drv(1, 0, 0, 0);
      drv(1, 0, 0, 0);
      chk(err_cnt[31:24] == 8'hff, "R5 saturation", 64'(err_cnt[31:24]), 64'hff);

      // random traffic
      for (int k = 0; k < 6000; k++) begin
         drv($urandom_range(0, 9) < 3, $urandom_range(0, 9) == 0,
             $urandom_range(0, 3), $urandom_range(0, 19) == 0);
         cell_rel = 4'($urandom) & {4{$urandom_range(0, 5) == 0}};
         perr_clr = $urandom_range(0, 29) == 0;
         if ($urandom_range(0, 99) == 0) poll_mode = ~poll_mode;
         if ($urandom_range(0, 199) == 0) par_odd = ~par_odd;
      end
      drv(1, 0, 0, 0);
      fin();
   end

endmodule